// File: doc/BRIEF.md
# Cascaded Digital Potentiometer Chain Master

This block is the host end of a three-wire serial link to a row of wiper-register devices wired in a daisy chain. Each device holds a 17-bit word: a stack-select bit and two 8-bit wiper codes. The devices shift data in on rising serial-clock edges and load the new word into their wipers when the enable drops. The master produces the enable, the serial clock and the outgoing data. It also produces an output-drive qualifier, and it samples the bit that returns from the far end of the chain.

A write command takes `NUM_DEV` 17-bit words from a parallel input and clocks them out in one transaction. A read command releases the data line so that the last device's cascade output loops back into the first device. The master then clocks exactly one full trip around the loop and captures every returning bit. The devices end the read holding what they held before it, and the captured words appear on a parallel output when the `done_o` pulse fires.

All timing is counted in system clock cycles, and each interval is set by a parameter: the serial clock half-period, the enable-to-first-edge setup, the hold after the last edge, and the idle gap between transactions.

Top module: `pch_host`

## Requirements
- R1: Every transaction has exactly 17×`NUM_DEV` rising serial-clock edges while the enable is high. The serial clock is low whenever the enable is low.
- R2: On a write, word k (bits `[17k+16:17k]` of `wr_frames_i`) is sent before word k+1. Each word is sent from bit 16 down to bit 0: bit 16 is the stack select, bits 15:8 are wiper-1 (MSB first) and bits 7:0 are wiper-0 (MSB first). Word 0 therefore ends up in the device farthest from the host.
- R3: During a read `ser_oe_o` stays low, and after the read every device holds its previous word.
- R4: When `done_o` fires after a read, word k of `rd_frames_o` equals the word held by the device that word k of a write would reach.
- R5: The enable is high for at least `SETUP_CYC` cycles before the first rising serial-clock edge.
- R6: The enable stays high for at least `HOLD_CYC` cycles after the last rising edge.
- R7: The enable stays low for at least `GAP_CYC` cycles between transactions, and the block stays busy for that gap.
- R8: Each high phase and each low phase of the serial clock between edges lasts exactly `HALF_CYC` cycles.
- R9: While the enable is high, `ser_dout_o` changes only on a falling edge of the serial clock.
- R10: `busy_o` rises the cycle after an accepted `start_i` and stays high until `done_o`. `done_o` is a single-cycle pulse with `busy_o` low. A `start_i` that arrives while busy has no effect.
- R11: Out of reset the enable, serial clock, busy and done outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transaction (accepted when idle) |
| read_i | input | 1 | 1 = read command, 0 = write command, sampled with start |
| wr_frames_i | input | 17×NUM_DEV | Words to write, word k at bits 17k+16:17k |
| busy_o | output | 1 | Transaction in progress, including the idle gap |
| done_o | output | 1 | One-cycle completion pulse |
| rd_frames_o | output | 17×NUM_DEV | Words captured by the last read |
| ser_en_o | output | 1 | Serial port enable to the chain |
| ser_clk_o | output | 1 | Serial clock to the chain |
| ser_dout_o | output | 1 | Serial data toward the first device |
| ser_oe_o | output | 1 | High when the host drives the data line |
| ser_din_i | input | 1 | Returning data from the last device |

## Verification
The hardest case is a read that is truly non-destructive. The chain must complete exactly one full loop, and every bit must be sampled before the devices shift again. Either an off-by-one bit count or a sample taken on the wrong side of an edge shows up only as rotated or corrupted device contents. The bench therefore models the chain of devices behaviourally, wires its feedback to `ser_din_i`, and writes asymmetric words with different stack bits and extreme wiper codes. It then reads twice and compares both the captured words and the model's device contents against the values written. A stray `start_i` fired in the middle of a write, and a start issued on the cycle right after `done_o`, exercise the rule that busy starts are ignored and the idle-gap rule.

// File: rtl/pch_pkg.sv
package pch_pkg;

    localparam int FRAME_W = 17;
    localparam int CODE_W  = 8;

    typedef struct packed {
        logic              stack_sel;
        logic [CODE_W-1:0] wiper1;
        logic [CODE_W-1:0] wiper0;
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pch_phase_timer.sv
module pch_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pch_shift_reg.sv
module pch_shift_reg #(
    parameter int WIDTH = 34
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
        end else if (load_i) begin
            data_o <= load_val_i;
        end else if (shift_i) begin
            data_o <= {data_o[WIDTH-2:0], bit_i};
        end
    end
endmodule

// File: rtl/pch_host.sv
module pch_host
    import pch_pkg::*;
#(
    parameter int NUM_DEV   = 2,
    parameter int HALF_CYC  = 10,
    parameter int SETUP_CYC = 10,
    parameter int HOLD_CYC  = 10,
    parameter int GAP_CYC   = 25
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic                       read_i,
    input  logic [NUM_DEV*FRAME_W-1:0] wr_frames_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [NUM_DEV*FRAME_W-1:0] rd_frames_o,
    output logic                       ser_en_o,
    output logic                       ser_clk_o,
    output logic                       ser_dout_o,
    output logic                       ser_oe_o,
    input  logic                       ser_din_i
);
    localparam int TOTAL_BITS = NUM_DEV * FRAME_W;
    localparam int BIT_W      = $clog2(TOTAL_BITS + 1);
    localparam int MAX_PHASE  = max4(HALF_CYC, SETUP_CYC, HOLD_CYC, GAP_CYC);
    localparam int CNT_W      = $clog2(MAX_PHASE + 1);

    seq_state_e             state_q, state_d;
    logic                   read_q;
    logic                   cap_q;
    logic [BIT_W-1:0]       bit_q;
    logic                   tm_load, tm_expired, cap_en, bit_inc, sh_shift, sh_load, finish;
    logic [CNT_W-1:0]       tm_val;
    logic [TOTAL_BITS-1:0]  load_vec, sreg;

    // word 0 sits at the top of the stream so it leaves first
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_order
        assign load_vec[(NUM_DEV-1-k)*FRAME_W +: FRAME_W] = wr_frames_i[k*FRAME_W +: FRAME_W];
        assign rd_frames_o[k*FRAME_W +: FRAME_W]          = sreg[(NUM_DEV-1-k)*FRAME_W +: FRAME_W];
    end

    pch_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tm_load),
        .val_i     (tm_val),
        .expired_o (tm_expired)
    );

    assign sh_load = (state_q == ST_IDLE) && start_i;

    pch_shift_reg #(.WIDTH(TOTAL_BITS)) shreg_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (sh_load),
        .load_val_i (load_vec),
        .shift_i    (sh_shift),
        .bit_i      (cap_q),
        .data_o     (sreg)
    );

    always_comb begin
        state_d  = state_q;
        tm_load  = 1'b0;
        tm_val   = '0;
        cap_en   = 1'b0;
        bit_inc  = 1'b0;
        sh_shift = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_SETUP;
                tm_load = 1'b1;
                tm_val  = CNT_W'(SETUP_CYC - 1);
            end
            ST_SETUP: if (tm_expired) begin
                state_d = ST_LOW;
                tm_load = 1'b1;
                tm_val  = CNT_W'(HALF_CYC - 1);
            end
            ST_LOW: if (tm_expired) begin
                state_d = ST_HIGH;
                tm_load = 1'b1;
                tm_val  = CNT_W'(HALF_CYC - 1);
                cap_en  = 1'b1;
            end
            ST_HIGH: if (tm_expired) begin
                sh_shift = 1'b1;
                bit_inc  = 1'b1;
                tm_load  = 1'b1;
                if (bit_q == BIT_W'(TOTAL_BITS - 1)) begin
                    state_d = ST_HOLD;
                    tm_val  = CNT_W'(HOLD_CYC - 1);
                end else begin
                    state_d = ST_LOW;
                    tm_val  = CNT_W'(HALF_CYC - 1);
                end
            end
            ST_HOLD: if (tm_expired) begin
                state_d = ST_GAP;
                tm_load = 1'b1;
                tm_val  = CNT_W'(GAP_CYC - 1);
            end
            ST_GAP: if (tm_expired) begin
                state_d = ST_IDLE;
                finish  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            read_q  <= 1'b0;
            cap_q   <= 1'b0;
            bit_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= finish;
            if (sh_load) begin
                read_q <= read_i;
                bit_q  <= '0;
            end else if (bit_inc) begin
                bit_q <= bit_q + 1'b1;
            end
            if (cap_en) begin
                cap_q <= ser_din_i;
            end
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign ser_en_o   = (state_q == ST_SETUP) || (state_q == ST_LOW) ||
                        (state_q == ST_HIGH)  || (state_q == ST_HOLD);
    assign ser_clk_o  = (state_q == ST_HIGH);
    assign ser_oe_o   = ser_en_o && !read_q;
    assign ser_dout_o = ser_oe_o && sreg[TOTAL_BITS-1];
endmodule

// File: rtl/pch_host_chk.sv
module pch_host_chk #(
    parameter int NUM_DEV = 2
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   busy_o,
    input logic                                   done_o,
    input logic                                   ser_en_o,
    input logic                                   ser_clk_o,
    input logic                                   ser_dout_o,
    input logic                                   ser_oe_o,
    input logic                                   read_q,
    input logic [$clog2(NUM_DEV*17+1)-1:0]        bit_q
);
    localparam int TOTAL_BITS = NUM_DEV * 17;

    assert_clk_gated_R1: assert property (@(posedge clk) disable iff (rst)
        !ser_en_o |-> !ser_clk_o);

    assert_bit_limit_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk_o) |-> (int'(bit_q) < TOTAL_BITS));

    assert_read_undriven_R3: assert property (@(posedge clk) disable iff (rst)
        read_q |-> !ser_oe_o);

    assert_setup_edge_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk_o) |-> $past(ser_en_o));

    assert_gap_busy_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_en_o) |-> busy_o);

    assert_dout_at_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk_o) |-> $stable(ser_dout_o));

    assert_dout_in_high_R9: assert property (@(posedge clk) disable iff (rst)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_dout_o));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ser_en_o && !busy_o && !done_o));
endmodule

bind pch_host pch_host_chk #(.NUM_DEV(NUM_DEV)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ser_en_o   (ser_en_o),
    .ser_clk_o  (ser_clk_o),
    .ser_dout_o (ser_dout_o),
    .ser_oe_o   (ser_oe_o),
    .read_q     (read_q),
    .bit_q      (bit_q)
);

// File: tb/pch_host_tb_top.sv
`timescale 1ns/1ps
module pch_host_tb_top;
    import pch_pkg::*;

    localparam int N     = 2;
    localparam int HALF  = 10;
    localparam int SETUP = 10;
    localparam int HOLD  = 10;
    localparam int GAP   = 25;
    localparam int TOT   = N * 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic rd = 1'b0;
    logic [TOT-1:0] wr = '0;
    logic busy, done, en, sclk, dout, oe, din;
    logic [TOT-1:0] rdata;

    always #2.5 clk = ~clk;

    pch_host #(.NUM_DEV(N), .HALF_CYC(HALF), .SETUP_CYC(SETUP),
               .HOLD_CYC(HOLD), .GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .read_i(rd), .wr_frames_i(wr),
        .busy_o(busy), .done_o(done), .rd_frames_o(rdata),
        .ser_en_o(en), .ser_clk_o(sclk), .ser_dout_o(dout), .ser_oe_o(oe),
        .ser_din_i(din)
    );

    // behavioural chain: dev[0] next to the host, dev[N-1] feeds back
    logic [16:0] dev [N];
    logic [16:0] wip [N];
    assign din = oe ? dout : dev[N-1][16];

    int checks = 0, errors = 0;
    bit finished = 0;
    bit cur_read = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle monitor, sampled on the falling system edge
    int cyc = 0, en_rise = 0, en_fall = 0, last_rise = 0, last_fall = 0, rises = 0, txns = 0;
    bit have_fall = 0, viol = 0, rviol = 0;
    logic pen = 0, pclk = 0, pdout = 0;

    initial begin
        for (int d = 0; d < N; d++) begin
            dev[d] = '0;
            wip[d] = '0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (sclk && !en) viol = 1;
            if (cur_read && oe) rviol = 1;
            if (en && !pen) begin
                en_rise = cyc;
                rises = 0;
                viol = 0;
                rviol = 0;
                if (have_fall) chk(cyc - en_fall >= GAP, "R7 idle gap", cyc - en_fall, GAP);
            end
            if (sclk && !pclk) begin
                logic fb;
                fb = din;
                for (int d = N-1; d > 0; d--) dev[d] = {dev[d][15:0], dev[d-1][16]};
                dev[0] = {dev[0][15:0], fb};
                rises++;
                if (rises == 1) chk(cyc - en_rise >= SETUP + 1, "R5 setup", cyc - en_rise, SETUP + 1);
                else            chk(cyc - last_fall == HALF, "R8 low width", cyc - last_fall, HALF);
                last_rise = cyc;
            end
            if (!sclk && pclk) begin
                chk(cyc - last_rise == HALF, "R8 high width", cyc - last_rise, HALF);
                last_fall = cyc;
            end
            if (en && pen && (dout != pdout) && !(!sclk && pclk)) viol = 1;
            if (!en && pen) begin
                chk(rises == TOT, "R1 edge count", rises, TOT);
                chk(cyc - last_rise >= HOLD + 1, "R6 hold", cyc - last_rise, HOLD + 1);
                chk(!viol, "R9/R1 data or clock outside rules", viol, 0);
                if (cur_read) chk(!rviol, "R3 host drove during read", rviol, 0);
                for (int d = 0; d < N; d++) wip[d] = dev[d];
                en_fall = cyc;
                have_fall = 1;
                txns++;
            end
            pen = en;
            pclk = sclk;
            pdout = dout;
        end
    end

    function automatic logic [16:0] mk(input bit s, input logic [7:0] a, input logic [7:0] b);
        frame_t f;
        f.stack_sel = s;
        f.wiper1 = a;
        f.wiper0 = b;
        return f;
    endfunction

    // run one transaction; optionally fire a stray start mid-way
    task automatic run(input bit is_rd, input logic [TOT-1:0] data, input bit stray);
        @(negedge clk);
        cur_read = is_rd;
        rd = is_rd;
        wr = data;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", busy, 1);
        if (stray) begin
            repeat (100) @(negedge clk);
            rd = 1'b0;
            wr = {mk(0, 8'h12, 8'h34), mk(1, 8'h56, 8'h78)};
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            rd = is_rd;
            wr = data;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(busy === 1'b0, "R10 idle at done", busy, 0);
    endtask

    task automatic do_write(input logic [TOT-1:0] data, input bit stray);
        int t0;
        t0 = txns;
        run(0, data, stray);
        chk(txns == t0 + 1, "R10 single transaction", txns - t0, 1);
        for (int k = 0; k < N; k++) begin
            chk(dev[N-1-k] == data[k*17 +: 17], "R2 device word", dev[N-1-k], data[k*17 +: 17]);
            chk(wip[N-1-k] == data[k*17 +: 17], "R2 latched wiper", wip[N-1-k], data[k*17 +: 17]);
        end
    endtask

    task automatic do_read();
        logic [16:0] snap [N];
        for (int d = 0; d < N; d++) snap[d] = dev[d];
        run(1, '0, 0);
        for (int k = 0; k < N; k++) begin
            chk(rdata[k*17 +: 17] == snap[N-1-k], "R4 read word", rdata[k*17 +: 17], snap[N-1-k]);
            chk(dev[k] == snap[k], "R3 device preserved", dev[k], snap[k]);
        end
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", done, 0);
        cur_read = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(en === 1'b0, "R11 enable low", en, 0);
        chk(sclk === 1'b0, "R11 clock low", sclk, 0);
        chk(busy === 1'b0, "R11 busy low", busy, 0);
        chk(done === 1'b0, "R11 done low", done, 0);

        do_write({mk(0, 8'h5A, 8'hC3), mk(1, 8'hA5, 8'h3C)}, 0);
        do_read();
        do_write({mk(1, 8'h00, 8'hFF), mk(1, 8'hFF, 8'h00)}, 1);
        do_read();
        do_write({mk(0, 8'h80, 8'h01), mk(0, 8'h01, 8'h80)}, 0);
        do_read();
        do_read();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule